// File: doc/BRIEF.md
# Bus Master Protection Attribute Controller

This block sits beside one bus master and labels each transfer it issues with a protection context number, a privilege flag and a security flag. The master may change its own context at any time by writing a new context number. That request is checked against a context mask. Only trusted configuration software can write the mask, and the master cannot reach it. A request the mask refuses is dropped without any error. The master finds out that the change failed by reading the context back and seeing that it differs from the value it wrote.

The trusted port also holds two attribute overrides and an arbitration priority. The privilege override applies only when the master cannot produce that attribute itself. The same holds for the security override. The priority is stored and presented to the arbiter, but this block does not use it. A build option adds a saved-context register, which boot firmware loads on the secure master.

Top module: `mattr_ctrl`

## Requirements
- R1: After reset, every stored value is 0: the context, the mask, the priority, both overrides and the saved context.
- R2: A master write of a context number c below 8 loads c into the context output at the next clock edge when bit c of the mask is 1. Bit i of the mask enables context i.
- R3: A master write of a context whose mask bit is 0 leaves the context output unchanged. Right after reset the mask is all zeros, so no master write succeeds until the trusted port grants contexts.
- R4: Mask bit 0 always reads 0, even when the trusted port writes a 1 there. As a result, a master write of context 0 is always refused, and once the context is non-zero it never returns to 0.
- R5: A master write of a context number from 8 to 15 is ignored, in the same way as a masked-off context.
- R6: A trusted write loads the mask, the privilege override, the security override and the 2-bit priority at the next edge. Master writes never change any of these fields.
- R7: With the default options, the privilege output follows the master's own privilege input combinationally. The security output comes from the stored override, and the master's own security input has no effect on it.
- R8: A boot load places the given value into the saved-context register at the next edge. Without a boot load, that register holds its value.
- R9: When a trusted write and a master write fall in the same cycle, the master request is judged against the mask held before that edge.
- R10: Shrinking the mask does not move the context that is already active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_wr_en | input | 1 | Master requests a context change |
| mst_wr_pc | input | 4 | Requested context number |
| cfg_wr_en | input | 1 | Trusted configuration write |
| cfg_mask | input | 8 | New context mask (bit 0 is discarded) |
| cfg_priv | input | 1 | New privilege override (1 = privileged) |
| cfg_nonsec | input | 1 | New security override (1 = non-secure) |
| cfg_prio | input | 2 | New arbitration priority |
| boot_save_en | input | 1 | Boot load of the saved context |
| boot_save_pc | input | 4 | Value for the saved context |
| xfer_priv_in | input | 1 | Privilege attribute produced by the master |
| xfer_nsec_in | input | 1 | Security attribute produced by the master |
| attr_pc | output | 4 | Current context; also serves as its read-back |
| attr_priv | output | 1 | Privilege attribute of outgoing transfers |
| attr_nonsec | output | 1 | Security attribute of outgoing transfers |
| arb_prio | output | 2 | Stored arbitration priority |
| ctx_mask_o | output | 8 | Stored context mask |
| saved_pc_o | output | 4 | Saved context |

## Verification
The properties assume that every input is driven to a known level from reset onward. They also assume that the context number on the master port is a plain 4-bit value, which may be out of range. The stimulus changes every input only at the falling clock edge, and it keeps all write strobes low while reset is active. The master port sweeps all sixteen encodings under several masks. This includes same-cycle collisions with trusted writes, so every refusal path is driven from inputs that stay within those assumptions.

// File: rtl/mattr_pkg.sv
package mattr_pkg;
  localparam int unsigned CTX_NUM_DEF = 8;
  localparam int unsigned PC_W_DEF    = 4;
  localparam int unsigned PRIO_W_DEF  = 2;

  typedef struct packed {
    logic priv;
    logic nonsec;
  } ovr_t;
endpackage

// File: rtl/mattr_ctx_gate.sv
module mattr_ctx_gate #(
  parameter int unsigned CTX_NUM = 8,
  parameter int unsigned PC_W    = 4
) (
  input  logic [PC_W-1:0]    req_pc,
  input  logic [CTX_NUM-1:0] mask,
  output logic               grant
);
  localparam int unsigned IDX_W = $clog2(CTX_NUM);
  localparam logic [PC_W:0] LIMIT = CTX_NUM[PC_W:0];

  logic in_range;

  always_comb begin
    in_range = ({1'b0, req_pc} < LIMIT);
    grant    = in_range && mask[req_pc[IDX_W-1:0]];
  end
endmodule

// File: rtl/mattr_pc_reg.sv
module mattr_pc_reg #(
  parameter int unsigned PC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] q
);
  logic [PC_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mattr_trusted_regs.sv
module mattr_trusted_regs
  import mattr_pkg::*;
#(
  parameter int unsigned CTX_NUM = 8,
  parameter int unsigned PRIO_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTX_NUM-1:0] wr_mask,
  input  ovr_t              wr_ovr,
  input  logic [PRIO_W-1:0] wr_prio,
  output logic [CTX_NUM-1:0] mask_q,
  output ovr_t              ovr_q,
  output logic [PRIO_W-1:0] prio_q
);
  localparam logic [CTX_NUM-1:0] ZERO_CTX_CLR = {{(CTX_NUM-1){1'b1}}, 1'b0};

  logic [CTX_NUM-1:0] mask_nxt;
  ovr_t               ovr_nxt;
  logic [PRIO_W-1:0]  prio_nxt;

  always_comb begin
    mask_nxt = mask_q;
    ovr_nxt  = ovr_q;
    prio_nxt = prio_q;
    if (wr_en) begin
      mask_nxt = wr_mask & ZERO_CTX_CLR;
      ovr_nxt  = wr_ovr;
      prio_nxt = wr_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ovr_q  <= '0;
      prio_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      ovr_q  <= ovr_nxt;
      prio_q <= prio_nxt;
    end
  end
endmodule

// File: rtl/mattr_ctrl.sv
module mattr_ctrl
  import mattr_pkg::*;
#(
  parameter int unsigned CTX_NUM         = CTX_NUM_DEF,
  parameter int unsigned PC_W            = PC_W_DEF,
  parameter int unsigned PRIO_W          = PRIO_W_DEF,
  parameter bit          HAS_SAVED       = 1'b1,
  parameter bit          MASTER_GEN_PRIV = 1'b1,
  parameter bit          MASTER_GEN_NS   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mst_wr_en,
  input  logic [PC_W-1:0]    mst_wr_pc,
  input  logic               cfg_wr_en,
  input  logic [CTX_NUM-1:0] cfg_mask,
  input  logic               cfg_priv,
  input  logic               cfg_nonsec,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic               boot_save_en,
  input  logic [PC_W-1:0]    boot_save_pc,
  input  logic               xfer_priv_in,
  input  logic               xfer_nsec_in,
  output logic [PC_W-1:0]    attr_pc,
  output logic               attr_priv,
  output logic               attr_nonsec,
  output logic [PRIO_W-1:0]  arb_prio,
  output logic [CTX_NUM-1:0] ctx_mask_o,
  output logic [PC_W-1:0]    saved_pc_o
);
  logic grant;
  logic pc_load;
  ovr_t cfg_ovr;
  ovr_t ovr_q;

  always_comb begin
    cfg_ovr.priv   = cfg_priv;
    cfg_ovr.nonsec = cfg_nonsec;
    pc_load        = mst_wr_en && grant;
  end

  mattr_ctx_gate #(.CTX_NUM(CTX_NUM), .PC_W(PC_W)) u_gate (
    .req_pc (mst_wr_pc),
    .mask   (ctx_mask_o),
    .grant  (grant)
  );

  mattr_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (pc_load),
    .load_val (mst_wr_pc),
    .q        (attr_pc)
  );

  mattr_trusted_regs #(.CTX_NUM(CTX_NUM), .PRIO_W(PRIO_W)) u_trust (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_mask (cfg_mask),
    .wr_ovr  (cfg_ovr),
    .wr_prio (cfg_prio),
    .mask_q  (ctx_mask_o),
    .ovr_q   (ovr_q),
    .prio_q  (arb_prio)
  );

  generate
    if (HAS_SAVED) begin : g_saved
      mattr_pc_reg #(.PC_W(PC_W)) u_saved (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (boot_save_en),
        .load_val (boot_save_pc),
        .q        (saved_pc_o)
      );
    end else begin : g_nosaved
      logic unused_save;
      assign unused_save = boot_save_en ^ (^boot_save_pc);
      assign saved_pc_o  = '0;
    end

    if (MASTER_GEN_PRIV) begin : g_priv_own
      logic unused_priv_ovr;
      assign unused_priv_ovr = ovr_q.priv;
      assign attr_priv       = xfer_priv_in;
    end else begin : g_priv_ovr
      logic unused_priv_in;
      assign unused_priv_in = xfer_priv_in;
      assign attr_priv      = ovr_q.priv;
    end

    if (MASTER_GEN_NS) begin : g_ns_own
      logic unused_ns_ovr;
      assign unused_ns_ovr = ovr_q.nonsec;
      assign attr_nonsec   = xfer_nsec_in;
    end else begin : g_ns_ovr
      logic unused_ns_in;
      assign unused_ns_in = xfer_nsec_in;
      assign attr_nonsec  = ovr_q.nonsec;
    end
  endgenerate
endmodule

// File: rtl/mattr_ctrl_chk.sv
module mattr_ctrl_chk #(
  parameter int unsigned CTX_NUM = 8,
  parameter int unsigned PC_W    = 4,
  parameter int unsigned PRIO_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mst_wr_en,
  input logic [PC_W-1:0]    mst_wr_pc,
  input logic               cfg_wr_en,
  input logic [PRIO_W-1:0]  cfg_prio,
  input logic               boot_save_en,
  input logic [PC_W-1:0]    attr_pc,
  input logic [PRIO_W-1:0]  arb_prio,
  input logic [CTX_NUM-1:0] ctx_mask_o,
  input logic [PC_W-1:0]    saved_pc_o
);
  localparam int unsigned IDX_W = $clog2(CTX_NUM);
  localparam logic [PC_W:0] LIMIT = CTX_NUM[PC_W:0];

  logic req_ok;
  assign req_ok = ({1'b0, mst_wr_pc} < LIMIT) && ctx_mask_o[mst_wr_pc[IDX_W-1:0]];

  assert_grant_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_wr_en && req_ok) |=> (attr_pc == $past(mst_wr_pc)));

  assert_refused_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_wr_en && !req_ok) |=> $stable(attr_pc));

  assert_no_return_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(attr_pc) != '0) |-> (attr_pc != '0));

  assert_mask_bit0_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_mask_o[0] == 1'b0));

  assert_pc_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, attr_pc} < LIMIT));

  assert_prio_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (arb_prio == $past(cfg_prio)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(ctx_mask_o));

  assert_saved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_save_en |=> $stable(saved_pc_o));
endmodule

bind mattr_ctrl mattr_ctrl_chk #(.CTX_NUM(CTX_NUM), .PC_W(PC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mst_wr_en    (mst_wr_en),
  .mst_wr_pc    (mst_wr_pc),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_prio     (cfg_prio),
  .boot_save_en (boot_save_en),
  .attr_pc      (attr_pc),
  .arb_prio     (arb_prio),
  .ctx_mask_o   (ctx_mask_o),
  .saved_pc_o   (saved_pc_o)
);

// File: tb/mattr_ctrl_test.sv
module mattr_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mst_wr_en, cfg_wr_en, boot_save_en;
  logic [3:0] mst_wr_pc, boot_save_pc;
  logic [7:0] cfg_mask;
  logic       cfg_priv, cfg_nonsec, xfer_priv_in, xfer_nsec_in;
  logic [1:0] cfg_prio;
  logic [3:0] attr_pc, saved_pc_o;
  logic       attr_priv, attr_nonsec;
  logic [1:0] arb_prio;
  logic [7:0] ctx_mask_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mattr_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .mst_wr_en(mst_wr_en), .mst_wr_pc(mst_wr_pc),
    .cfg_wr_en(cfg_wr_en), .cfg_mask(cfg_mask), .cfg_priv(cfg_priv),
    .cfg_nonsec(cfg_nonsec), .cfg_prio(cfg_prio),
    .boot_save_en(boot_save_en), .boot_save_pc(boot_save_pc),
    .xfer_priv_in(xfer_priv_in), .xfer_nsec_in(xfer_nsec_in),
    .attr_pc(attr_pc), .attr_priv(attr_priv), .attr_nonsec(attr_nonsec),
    .arb_prio(arb_prio), .ctx_mask_o(ctx_mask_o), .saved_pc_o(saved_pc_o)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // expected {pc, mask, prio, priv, nonsec, saved}
  logic [19:0] exp_q[$];
  string       tag_q[$];

  logic [3:0] m_pc = 4'd0, m_saved = 4'd0;
  logic [7:0] m_mask = 8'd0;
  logic [1:0] m_prio = 2'd0;
  logic       m_priv = 1'b0, m_ns = 1'b0;

  task automatic step(input logic mw, input logic [3:0] mpc,
                      input logic cw, input logic [7:0] cm, input logic cp,
                      input logic cn, input logic [1:0] cpr,
                      input logic bs, input logic [3:0] bpc,
                      input logic xp, input logic xn, input string tag);
    @(negedge clk);
    mst_wr_en = mw; mst_wr_pc = mpc;
    cfg_wr_en = cw; cfg_mask = cm; cfg_priv = cp; cfg_nonsec = cn; cfg_prio = cpr;
    boot_save_en = bs; boot_save_pc = bpc;
    xfer_priv_in = xp; xfer_nsec_in = xn;
    if (mw && mpc < 4'd8 && m_mask[mpc[2:0]]) m_pc = mpc;
    if (cw) begin
      m_mask = cm & 8'hFE; m_priv = cp; m_ns = cn; m_prio = cpr;
    end
    if (bs) m_saved = bpc;
    exp_q.push_back({m_pc, m_mask, m_prio, xp, m_ns, m_saved});
    tag_q.push_back(tag);
  endtask

  task automatic mst_wr(input logic [3:0] pc, input string tag);
    step(1'b1, pc, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic cfg_wr(input logic [7:0] m, input logic p, input logic n,
                        input logic [1:0] pr, input string tag);
    step(1'b0, 4'd0, 1'b1, m, p, n, pr, 1'b0, 4'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [19:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {attr_pc, ctx_mask_o, arb_prio, attr_priv, attr_nonsec, saved_pc_o};
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0;
    mst_wr_en = 0; mst_wr_pc = 0; cfg_wr_en = 0; cfg_mask = 0; cfg_priv = 0;
    cfg_nonsec = 0; cfg_prio = 0; boot_save_en = 0; boot_save_pc = 0;
    xfer_priv_in = 0; xfer_nsec_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    n_chk++;
    if ({attr_pc, ctx_mask_o, arb_prio, attr_nonsec, saved_pc_o} !== 17'd0) begin
      n_fail++;
      $display("FAIL R1 reset actual=%h expected=0",
               {attr_pc, ctx_mask_o, arb_prio, attr_nonsec, saved_pc_o});
    end

    mst_wr(4'd3, "R3 no grant after reset");
    cfg_wr(8'h06, 1'b1, 1'b1, 2'd2, "R6 trusted load");
    mst_wr(4'd2, "R2 permitted pc2");
    mst_wr(4'd1, "R2 permitted pc1");
    mst_wr(4'd3, "R3 masked pc3");
    mst_wr(4'd0, "R4 pc0 refused");
    mst_wr(4'd9, "R5 pc9 ignored");
    cfg_wr(8'hFF, 1'b0, 1'b1, 2'd3, "R4 mask bit0 cleared");
    mst_wr(4'd0, "R4 pc0 refused full mask");
    mst_wr(4'd8, "R5 pc8 ignored");
    mst_wr(4'd15, "R5 pc15 ignored");
    mst_wr(4'd7, "R2 permitted pc7");
    step(1'b1, 4'd5, 1'b1, 8'h10, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0, 1'b0, 1'b0, "R9 old mask grants");
    step(1'b1, 4'd6, 1'b1, 8'hFE, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0, 1'b0, 1'b0, "R9 old mask refuses");
    mst_wr(4'd4, "R2 permitted pc4");
    cfg_wr(8'h02, 1'b0, 1'b0, 2'd0, "R10 revoke keeps pc");
    mst_wr(4'd4, "R10 revoked pc4 refused");
    step(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 1'b1, "R7 own priv, ns input ignored");
    step(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b1, "R7 own priv low");
    step(1'b0, 4'd0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b1, 4'd5, 1'b0, 1'b0, "R8 boot load");
    step(1'b1, 4'd1, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 4'd9, 1'b0, 1'b0, "R8 saved holds");
    cfg_wr(8'h5A, 1'b1, 1'b0, 2'd2, "R6 mask 5A");
    for (int i = 0; i < 16; i++) mst_wr(i[3:0], "R3 sweep mask 5A");
    cfg_wr(8'hA5, 1'b0, 1'b1, 2'd1, "R6 mask A5");
    for (int i = 15; i >= 0; i--) mst_wr(i[3:0], "R2 sweep mask A5");

    @(negedge clk);
    mst_wr_en = 0; cfg_wr_en = 0; boot_save_en = 0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule